// File: doc/BRIEF.md
# Serial Boot Image Loader

This block takes a program or data image arriving on an asynchronous serial line (8 data bits, no parity, 1 stop bit, 115200 baud by default) and writes it into a word-addressed memory with no processor involved. It samples each bit in the middle of its period. It packs every four accepted bytes into a 32-bit word and issues one write per word, with the address advancing by one after each write.

From reset the block keeps the processor in hold. After at least one byte has arrived, the block measures how long the line stays quiet. When the quiet time just exceeds the configured timeout (half a second by default, counted in system clocks), it drops the hold and emits a one-cycle start pulse. From then until the next reset, the serial input has no effect. After a reset the block starts a fresh load at address zero.

Top module: `serial_image_loader`

## Requirements
- R1: While reset is applied and right after it, `coreHold` is high and `memWe`, `startPulse` and `loadActive` are low.
- R2: Four accepted bytes form one word. The first byte goes to bits 7:0 and the fourth byte to bits 31:24. Each word is written with a `memWe` pulse that lasts exactly one cycle.
- R3: Word writes go to addresses 0, 1, 2, … in order. The address advances by one after every written word.
- R4: A frame whose stop bit samples low is dropped and does not count toward the word. The receiver then waits for the line to return high before it looks for a new start bit.
- R5: A start bit is accepted only if the line is still low half a bit period (CLK_HZ/BAUD/2 clocks) after the falling edge. A shorter low pulse produces no byte. Data and stop bits are then sampled every CLK_HZ/BAUD clocks.
- R6: The hold is never released and no start pulse occurs unless at least one byte has been accepted since reset. `loadActive` is high exactly when a byte has been accepted and the hold is still asserted.
- R7: The hold is released once the line has been idle for CLK_HZ/1000*IDLE_MS+1 clocks after the last accepted byte. `startPulse` is high for one cycle, in the same cycle in which `coreHold` first reads low.
- R8: Every detected start bit clears the idle count, so a byte arriving before the timeout postpones the release.
- R9: After release, serial input is ignored. No writes occur and `coreHold` stays low until reset.
- R10: Bytes of an incomplete word that are pending at release are never written.
- R11: A reset restarts loading at address 0 and holds the core again until the next idle timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Serial receive line, idle high |
| memAddr | output | ADDR_W (14) | Word address of the write |
| memWData | output | DATA_W (32) | Word to write |
| memWe | output | 1 | Write enable, one cycle per word |
| coreHold | output | 1 | Keeps the processor in reset while high |
| startPulse | output | 1 | One-cycle pulse when the processor is released |
| loadActive | output | 1 | Status: bytes received, load still in progress |

## Verification
The bound checker watches the write port and the release on every cycle. It checks that each write is a single-cycle pulse, that addresses follow a running word count, and that writes stop after release. It also checks that the hold never returns without reset, and that the start pulse is single, coincides with the falling hold, follows a received byte, and comes only after the raw line has been high for at least the idle window. The little-endian byte order, the rejection of short glitches and bad stop bits, the restart of the idle count by a new frame, the dropping of a partial word, and the restart at address zero after reset depend on serial byte sequences. Only the directed bench scenarios show those.

// File: rtl/sil_pkg.sv
package sil_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP  = 3'd3,
    RX_BREAK = 3'd4,
    RUN      = 3'd5
  } ctrlState_t;

  // control -> datapath
  typedef struct packed {
    logic clrBaud;
    logic shiftBit;
    logic takeByte;
    logic clrIdle;
    logic runIdle;
  } strobes_t;

  // datapath -> control
  typedef struct packed {
    logic rxLevel;
    logic halfHit;
    logic fullHit;
    logic lastBit;
    logic idleDone;
  } flags_t;

endpackage

// File: rtl/sil_datapath.sv
module sil_datapath
  import sil_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  parameter int IDLE_CYCLES  = 25000001,
  parameter int ADDR_W       = 14,
  parameter int DATA_W       = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  strobes_t          stb,
  output flags_t            flg,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              memWe
);

  localparam int HALF_BIT = CLKS_PER_BIT / 2;
  localparam int BAUD_W   = $clog2(CLKS_PER_BIT + 1);
  localparam int IDLE_W   = $clog2(IDLE_CYCLES + 1);
  localparam int BYTES    = DATA_W / 8;
  localparam int LANE_W   = (BYTES > 1) ? $clog2(BYTES) : 1;

  // input synchronizer, idle level is high
  logic [SYNC_STAGES-1:0] syncReg;
  always_ff @(posedge clk) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxIn};
  end
  assign flg.rxLevel = syncReg[SYNC_STAGES-1];

  // bit period timer
  logic [BAUD_W-1:0] baudCnt;
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrBaud) baudCnt <= '0;
    else                      baudCnt <= baudCnt + BAUD_W'(1);
  end
  assign flg.halfHit = (baudCnt == BAUD_W'(HALF_BIT - 1));
  assign flg.fullHit = (baudCnt == BAUD_W'(CLKS_PER_BIT - 1));

  // data bit shifter, LSB first on the line
  logic [2:0] bitIdx;
  logic [7:0] shiftReg;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx   <= '0;
      shiftReg <= '0;
    end else if (stb.shiftBit) begin
      bitIdx   <= bitIdx + 3'd1;
      shiftReg <= {flg.rxLevel, shiftReg[7:1]};
    end
  end
  assign flg.lastBit = (bitIdx == 3'd7);

  // byte to word assembly
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] wordBuf;
  logic [DATA_W-1:0] fullWord;
  logic              wordDone;

  assign wordDone = stb.takeByte && (lane == LANE_W'(BYTES - 1));

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)                                    wordBuf[g*8 +: 8] <= '0;
      else if (stb.takeByte && lane == LANE_W'(g))  wordBuf[g*8 +: 8] <= shiftReg;
    end
  end

  always_comb begin
    fullWord = wordBuf;
    fullWord[(BYTES-1)*8 +: 8] = shiftReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lane <= '0;
    end else if (stb.takeByte) begin
      lane <= wordDone ? '0 : lane + LANE_W'(1);
    end
  end

  // registered memory write port
  logic [ADDR_W-1:0] addrCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt  <= '0;
      memAddr  <= '0;
      memWData <= '0;
      memWe    <= 1'b0;
    end else begin
      memWe <= wordDone;
      if (wordDone) begin
        memAddr  <= addrCnt;
        memWData <= fullWord;
        addrCnt  <= addrCnt + ADDR_W'(1);
      end
    end
  end

  // quiet-line timer, saturates at the limit
  logic [IDLE_W-1:0] idleCnt;
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrIdle)          idleCnt <= '0;
    else if (stb.runIdle && !flg.idleDone) idleCnt <= idleCnt + IDLE_W'(1);
  end
  assign flg.idleDone = (idleCnt == IDLE_W'(IDLE_CYCLES));

endmodule

// File: rtl/sil_ctrl.sv
module sil_ctrl
  import sil_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  flags_t   flg,
  output strobes_t stb,
  output logic     coreHold,
  output logic     startPulse,
  output logic     loadActive
);

  ctrlState_t state, nextState;
  logic       gotByte;
  logic       releaseNow;

  always_comb begin
    stb        = '0;
    releaseNow = 1'b0;
    nextState  = state;
    unique case (state)
      RX_IDLE: begin
        stb.clrBaud = 1'b1;
        if (!flg.rxLevel) begin
          stb.clrIdle = 1'b1;
          nextState   = RX_START;
        end else if (gotByte) begin
          stb.runIdle = 1'b1;
          if (flg.idleDone) begin
            releaseNow = 1'b1;
            nextState  = RUN;
          end
        end
      end
      RX_START: begin
        if (flg.halfHit) begin
          stb.clrBaud = 1'b1;
          nextState   = flg.rxLevel ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (flg.fullHit) begin
          stb.shiftBit = 1'b1;
          stb.clrBaud  = 1'b1;
          if (flg.lastBit) nextState = RX_STOP;
        end
      end
      RX_STOP: begin
        if (flg.fullHit) begin
          stb.clrBaud = 1'b1;
          if (flg.rxLevel) begin
            stb.takeByte = 1'b1;
            nextState    = RX_IDLE;
          end else begin
            nextState = RX_BREAK;
          end
        end
      end
      RX_BREAK: begin
        stb.clrBaud = 1'b1;
        if (flg.rxLevel) nextState = RX_IDLE;
      end
      RUN: begin
        stb.clrBaud = 1'b1;
      end
      default: nextState = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= RX_IDLE;
      gotByte    <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      state      <= nextState;
      gotByte    <= gotByte | stb.takeByte;
      startPulse <= releaseNow;
    end
  end

  assign coreHold   = (state != RUN);
  assign loadActive = gotByte && (state != RUN);

endmodule

// File: rtl/serial_image_loader.sv
module serial_image_loader
  import sil_pkg::*;
#(
  parameter int CLK_HZ      = 50000000,
  parameter int BAUD        = 115200,
  parameter int IDLE_MS     = 500,
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              memWe,
  output logic              coreHold,
  output logic              startPulse,
  output logic              loadActive
);

  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;
  localparam int IDLE_CYCLES  = (CLK_HZ / 1000) * IDLE_MS + 1;

  strobes_t stb;
  flags_t   flg;

  sil_datapath #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .IDLE_CYCLES  (IDLE_CYCLES),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxIn     (rxIn),
    .stb      (stb),
    .flg      (flg),
    .memAddr  (memAddr),
    .memWData (memWData),
    .memWe    (memWe)
  );

  sil_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flg        (flg),
    .stb        (stb),
    .coreHold   (coreHold),
    .startPulse (startPulse),
    .loadActive (loadActive)
  );

endmodule

// File: rtl/sil_checker.sv
module sil_checker #(
  parameter int CLK_HZ  = 50000000,
  parameter int IDLE_MS = 500,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxIn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWData,
  input logic              memWe,
  input logic              coreHold,
  input logic              startPulse,
  input logic              loadActive
);

  localparam int IDLE_CYCLES = (CLK_HZ / 1000) * IDLE_MS + 1;
  localparam int QW          = $clog2(IDLE_CYCLES + 2);

  logic [ADDR_W-1:0] expAddr;
  logic [QW-1:0]     quietCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expAddr  <= '0;
      quietCnt <= '0;
    end else begin
      if (memWe) expAddr <= expAddr + ADDR_W'(1);
      if (!rxIn)                        quietCnt <= '0;
      else if (quietCnt != '1)          quietCnt <= quietCnt + QW'(1);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (coreHold && !memWe && !startPulse && !loadActive));

  // R2
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R3
  write_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr == expAddr));

  // R6
  start_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(loadActive));

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadActive |-> coreHold);

  // R7
  single_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R7
  release_with_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreHold) |-> startPulse);

  // R7
  quiet_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (quietCnt >= QW'(IDLE_CYCLES)));

  // R9
  no_write_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !coreHold |-> !memWe);

  // R9
  hold_stays_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !coreHold |=> !coreHold);

endmodule

bind serial_image_loader sil_checker #(
  .CLK_HZ  (CLK_HZ),
  .IDLE_MS (IDLE_MS),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) i_sil_checker (
  .clk        (clk),
  .rstN       (rstN),
  .rxIn       (rxIn),
  .memAddr    (memAddr),
  .memWData   (memWData),
  .memWe      (memWe),
  .coreHold   (coreHold),
  .startPulse (startPulse),
  .loadActive (loadActive)
);

// File: tb/test_serial_image_loader.sv
module test_serial_image_loader;

  localparam int CLK_HZ  = 80000;
  localparam int BAUD    = 10000;
  localparam int IDLE_MS = 5;
  localparam int BIT     = CLK_HZ / BAUD;
  localparam int IDLE    = (CLK_HZ / 1000) * IDLE_MS + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxIn = 1'b1;
  logic [13:0] memAddr;
  logic [31:0] memWData;
  logic        memWe, coreHold, startPulse, loadActive;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  int pulseCount = 0;
  bit done = 1'b0;
  logic [13:0] wAddr [16];
  logic [31:0] wData [16];

  always #5 clk = ~clk;

  serial_image_loader #(
    .CLK_HZ (CLK_HZ), .BAUD (BAUD), .IDLE_MS (IDLE_MS)
  ) i_serial_image_loader (
    .clk (clk), .rstN (rstN), .rxIn (rxIn),
    .memAddr (memAddr), .memWData (memWData), .memWe (memWe),
    .coreHold (coreHold), .startPulse (startPulse), .loadActive (loadActive)
  );

  always @(negedge clk) begin
    if (memWe) begin
      if (wrCount < 16) begin
        wAddr[wrCount] = memAddr;
        wData[wrCount] = memWData;
      end
      wrCount++;
    end
    if (startPulse) pulseCount++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] b, input bit goodStop);
    rxIn = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxIn = goodStop;
    repeat (BIT) @(negedge clk);
    if (!goodStop) begin
      rxIn = 1'b1;
      repeat (2 * BIT) @(negedge clk);
    end
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(coreHold == 1'b1, "R1 hold in reset", coreHold, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(coreHold == 1'b1, "R1 hold after reset", coreHold, 1);
    check(memWe == 1'b0, "R1 memWe", memWe, 0);
    check(startPulse == 1'b0, "R1 startPulse", startPulse, 0);
    check(loadActive == 1'b0, "R1 loadActive", loadActive, 0);
  endtask

  task automatic test_glitch();
    rxIn = 1'b0;
    repeat (2) @(negedge clk);
    rxIn = 1'b1;
    repeat (IDLE + 50) @(negedge clk);
    check(loadActive == 1'b0, "R5 glitch gave no byte", loadActive, 0);
    check(wrCount == 0, "R5 no write from glitch", wrCount, 0);
    check(coreHold == 1'b1, "R6 no release without byte", coreHold, 1);
    check(pulseCount == 0, "R6 no start pulse", pulseCount, 0);
  endtask

  task automatic test_words();
    for (int i = 1; i <= 8; i++) sendFrame(8'(i * 8'h11), 1'b1);
    repeat (4) @(negedge clk);
    check(wrCount == 2, "R2 two words written", wrCount, 2);
    check(wData[0] == 32'h44332211, "R2 first word", wData[0], 32'h44332211);
    check(wData[1] == 32'h88776655, "R2 second word", wData[1], 32'h88776655);
    check(wAddr[0] == 14'd0, "R3 first address", wAddr[0], 0);
    check(wAddr[1] == 14'd1, "R3 second address", wAddr[1], 1);
    check(loadActive == 1'b1 && coreHold == 1'b1, "R6 status while loading", loadActive, 1);
  endtask

  task automatic test_frame_error();
    sendFrame(8'hAA, 1'b0);
    for (int i = 1; i <= 4; i++) sendFrame(8'hC0 + 8'(i), 1'b1);
    repeat (4) @(negedge clk);
    check(wrCount == 3, "R4 bad frame not counted", wrCount, 3);
    check(wData[2] == 32'hC4C3C2C1, "R4 word after bad frame", wData[2], 32'hC4C3C2C1);
    check(wAddr[2] == 14'd2, "R3 third address", wAddr[2], 2);
  endtask

  task automatic test_idle_clear();
    sendFrame(8'h5A, 1'b1);
    repeat (IDLE - 100) @(negedge clk);
    sendFrame(8'h5B, 1'b1);
    repeat (IDLE - 20) @(negedge clk);
    check(coreHold == 1'b1, "R8 new frame restarts idle count", coreHold, 1);
    check(pulseCount == 0, "R8 no early start pulse", pulseCount, 0);
  endtask

  task automatic test_release();
    sendFrame(8'h5C, 1'b1);
    repeat (IDLE - 20) @(negedge clk);
    check(coreHold == 1'b1, "R7 not released early", coreHold, 1);
    repeat (40) @(negedge clk);
    check(coreHold == 1'b0, "R7 released after idle", coreHold, 0);
    check(pulseCount == 1, "R7 one start pulse", pulseCount, 1);
    check(loadActive == 1'b0, "R6 status clears on release", loadActive, 0);
    check(wrCount == 3, "R10 partial word dropped", wrCount, 3);
  endtask

  task automatic test_ignore();
    for (int i = 0; i < 4; i++) sendFrame(8'hE0 + 8'(i), 1'b1);
    repeat (IDLE + 20) @(negedge clk);
    check(wrCount == 3, "R9 no write after release", wrCount, 3);
    check(coreHold == 1'b0, "R9 hold stays low", coreHold, 0);
    check(pulseCount == 1, "R9 no further pulse", pulseCount, 1);
  endtask

  task automatic test_reload();
    applyReset();
    check(coreHold == 1'b1, "R11 hold again after reset", coreHold, 1);
    for (int i = 0; i < 4; i++) sendFrame(8'hD0 + 8'(i), 1'b1);
    repeat (4) @(negedge clk);
    check(wrCount == 4, "R11 write after reload", wrCount, 4);
    check(wAddr[3] == 14'd0, "R11 address restarts at zero", wAddr[3], 0);
    check(wData[3] == 32'hD3D2D1D0, "R11 reload data", wData[3], 32'hD3D2D1D0);
    repeat (IDLE + 50) @(negedge clk);
    check(coreHold == 1'b0 && pulseCount == 2, "R11 released again", pulseCount, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_glitch();
    test_words();
    test_frame_error();
    test_idle_clear();
    test_release();
    test_ignore();
    test_reload();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule